// File: doc/BRIEF.md
# Indexed Hardware Event Counter Unit

This block is a bank of event counters that a processor programs through a simple register port made of an address, write data, write enable and a combinational read-data output. Each counter watches one bit of an event vector, which its configuration picks with a condition code. A counter counts only while a global run bit is set. It can also be limited to user-mode or to kernel-mode activity, as given by a mode input. Software first writes a counter-select register. After that, the configuration, count, threshold and snapshot registers all refer to the chosen counter.

A counter can raise a threshold interrupt. One cycle after its count equals its threshold, the counter's active bit is set, provided its enable bit is set. The interrupt output is the OR of all active bits that are still enabled. Software clears active bits by writing ones, and this also clears the matching enable bits. A snapshot command copies the selected counter into a holding register, so both halves of a wide count are read coherently. A read-only build word reports the shape of the bank. A second selector gives access to an 8-character name for each condition.

Top module: `evcnt_bank`

## Requirements
- R1: The counter-select register (address 1) picks which counter the configuration, count and threshold registers act on. While it holds a value of NCNT or more, writes to those registers change nothing and reads of them return 0.
- R2: Writing address 0 with bit 1 set copies the selected counter's full value into the snapshot registers (low word at address 7, upper bits at address 8) on that clock edge. The snapshot then holds while the counter keeps running.
- R3: Bit 0 of the control register (address 0) is a global run enable. While it is 0 no counter advances. Control bits 31:16 always read 0, and writes to them have no effect.
- R4: Configuration bits 14:0 (address 2) choose event input `evt_in[code]`, and the counter adds one on each clock edge where that input is high. Code 0, and any code of NCOND or more, never counts.
- R5: Configuration bit 16 limits counting to `user_mode`=1, and bit 17 limits it to `user_mode`=0.
- R6: Address 3 loads count bits 31:0 and address 4 loads the count bits above 31. Reads of these addresses return the live count. The count is 32+16*SZ bits wide and wraps.
- R7: When an enabled counter's count equals its threshold (address 5 low, address 6 high), its bit in the active register (address 10) is set on the next clock edge. A counter whose enable bit (address 9) is clear never sets its active bit. `irq` is the OR of active AND enable.
- R8: Writing ones to address 10 clears those active bits and also the matching enable bits.
- R9: Address 11 reads as: bit 0 = 1 (present), bits 13:8 = NCNT, bit 14 = 1 (interrupt support), bits 17:16 = SZ, bits 31:24 = NCOND, all other bits 0.
- R10: Address 12 selects a condition. Addresses 13 and 14 return characters 0-3 and 4-7 of its name, little-endian with character 0 in bits 7:0. Code 0 is named "NEVER" padded with three spaces. Code k is named "EVT_" followed by four upper-case hex digits of k. Codes of NCOND or more read as 0.
- R11: After reset every count, threshold, configuration, enable and active bit is 0, run is 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data (combinational) |
| evt_in | input | NCOND | Event condition inputs |
| user_mode | input | 1 | 1 while the core runs in user mode |
| irq | output | 1 | Threshold interrupt request |

## Verification
A wrong count, configuration or run state appears in the count read-back after the burst of events that exposed it. A lost or extra increment therefore shows up as soon as the count is read. A faulty select decode shows up when the other counters are read back, since a write meant for one counter lands on another. Interrupt faults appear at `irq` within one cycle of the threshold match, or as an enable bit that reads back set after a clearing write. A snapshot fault shows up as a value that differs from the count captured at the instant of the command, most clearly when that capture crosses a 32-bit carry.

// File: rtl/evb_pkg.sv
package evb_pkg;

  typedef enum logic [3:0] {
    RA_CTRL  = 4'd0,
    RA_SEL   = 4'd1,
    RA_CFG   = 4'd2,
    RA_CNTL  = 4'd3,
    RA_CNTH  = 4'd4,
    RA_THRL  = 4'd5,
    RA_THRH  = 4'd6,
    RA_SNPL  = 4'd7,
    RA_SNPH  = 4'd8,
    RA_IEN   = 4'd9,
    RA_IACT  = 4'd10,
    RA_BUILD = 4'd11,
    RA_CIDX  = 4'd12,
    RA_NAME0 = 4'd13,
    RA_NAME1 = 4'd14
  } reg_addr_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_SNAP_BIT = 1;
  localparam int CFG_USER_BIT  = 16;
  localparam int CFG_KERN_BIT  = 17;

  typedef struct packed {
    logic        kern_only;
    logic        user_only;
    logic [14:0] cond;
  } cfg_t;

  function automatic logic [7:0] hex_ch(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

  function automatic logic [63:0] cond_name(input logic [15:0] idx);
    logic [7:0]  ch [8];
    logic [63:0] res;
    if (idx == 16'd0) begin
      ch[0] = "N"; ch[1] = "E"; ch[2] = "V"; ch[3] = "E";
      ch[4] = "R"; ch[5] = " "; ch[6] = " "; ch[7] = " ";
    end else begin
      ch[0] = "E"; ch[1] = "V"; ch[2] = "T"; ch[3] = "_";
      ch[4] = hex_ch(idx[15:12]);
      ch[5] = hex_ch(idx[11:8]);
      ch[6] = hex_ch(idx[7:4]);
      ch[7] = hex_ch(idx[3:0]);
    end
    for (int b = 0; b < 8; b++) res[8*b +: 8] = ch[b];
    return res;
  endfunction

endpackage

// File: rtl/evb_counter.sv
module evb_counter
  import evb_pkg::*;
#(
  parameter int CW    = 48,
  parameter int NCOND = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              user_mode,
  input  logic [NCOND-1:0]  evt_in,
  input  logic              cfg_we,
  input  cfg_t              cfg_d,
  input  logic              cnt_we_lo,
  input  logic              cnt_we_hi,
  input  logic              thr_we_lo,
  input  logic              thr_we_hi,
  input  logic [31:0]       wdata,
  output cfg_t              cfg_q,
  output logic [CW-1:0]     cnt_q,
  output logic [CW-1:0]     thr_q,
  output logic              hit
);
  localparam int HW = CW - 32;

  logic          evt_hit, priv_ok, inc, cnt_en, thr_en;
  logic [CW-1:0] cnt_d, thr_d;

  always_comb begin
    evt_hit = 1'b0;
    for (int k = 0; k < NCOND; k++)
      if (k != 0 && cfg_q.cond == 15'(k)) evt_hit = evt_in[k];
    priv_ok = !(cfg_q.user_only && !user_mode) && !(cfg_q.kern_only && user_mode);
    inc     = run && evt_hit && priv_ok;
    cnt_en  = cnt_we_lo || cnt_we_hi || inc;
    if (cnt_we_lo)      cnt_d = {cnt_q[CW-1:32], wdata};
    else if (cnt_we_hi) cnt_d = {wdata[HW-1:0], cnt_q[31:0]};
    else                cnt_d = cnt_q + CW'(1);
    thr_en = thr_we_lo || thr_we_hi;
    thr_d  = thr_we_lo ? {thr_q[CW-1:32], wdata} : {wdata[HW-1:0], thr_q[31:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
      thr_q <= '0;
    end else begin
      if (cfg_we) cfg_q <= cfg_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (thr_en) thr_q <= thr_d;
    end
  end

  assign hit = (cnt_q == thr_q);
endmodule

// File: rtl/evb_irq.sv
module evb_irq #(
  parameter int NCNT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCNT-1:0] hit,
  input  logic            ien_we,
  input  logic            iact_we,
  input  logic [NCNT-1:0] wbits,
  output logic [NCNT-1:0] ien_q,
  output logic [NCNT-1:0] act_q,
  output logic            irq
);
  logic [NCNT-1:0] clr, ien_d, act_d;

  always_comb begin
    clr   = iact_we ? wbits : '0;
    ien_d = (ien_we ? wbits : ien_q) & ~clr;
    act_d = (act_q | (hit & ien_q)) & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      act_q <= '0;
    end else begin
      ien_q <= ien_d;
      act_q <= act_d;
    end
  end

  assign irq = |(act_q & ien_q);
endmodule

// File: rtl/evb_names.sv
module evb_names
  import evb_pkg::*;
#(
  parameter int NCOND = 8
) (
  input  logic [15:0] cidx,
  output logic [31:0] name_lo,
  output logic [31:0] name_hi
);
  logic [63:0] nm;
  always_comb begin
    nm      = (cidx < 16'(NCOND)) ? cond_name(cidx) : 64'd0;
    name_lo = nm[31:0];
    name_hi = nm[63:32];
  end
endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank
  import evb_pkg::*;
#(
  parameter int NCNT  = 4,
  parameter int NCOND = 8,
  parameter int SZ    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [NCOND-1:0] evt_in,
  input  logic             user_mode,
  output logic             irq
);
  localparam int CW = 32 + 16 * SZ;

  logic [4:0]         sel_q, sel_d;
  logic [15:0]        cidx_q, cidx_d;
  logic               run_q, run_d;
  logic [CW-1:0]      snap_q, snap_d;
  logic               snap_en, sel_ok;
  logic [CW-1:0]      cnt_arr [NCNT];
  logic [CW-1:0]      thr_arr [NCNT];
  cfg_t               cfg_arr [NCNT];
  logic [NCNT-1:0]    hit, ien_q, act_q;
  logic [NCNT*CW-1:0] cnt_flat;
  logic [CW-1:0]      sel_cnt, sel_thr;
  cfg_t               sel_cfg, cfg_d;
  logic [31:0]        name_lo, name_hi;

  assign sel_ok = (sel_q < 5'(NCNT));
  assign cfg_d  = '{kern_only: wdata[CFG_KERN_BIT], user_only: wdata[CFG_USER_BIT],
                    cond: wdata[14:0]};

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    logic mine;
    assign mine = wr_en && sel_ok && (sel_q == 5'(i));
    evb_counter #(.CW(CW), .NCOND(NCOND)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run_q), .user_mode(user_mode), .evt_in(evt_in),
      .cfg_we(mine && addr == RA_CFG), .cfg_d(cfg_d),
      .cnt_we_lo(mine && addr == RA_CNTL), .cnt_we_hi(mine && addr == RA_CNTH),
      .thr_we_lo(mine && addr == RA_THRL), .thr_we_hi(mine && addr == RA_THRH),
      .wdata(wdata), .cfg_q(cfg_arr[i]), .cnt_q(cnt_arr[i]), .thr_q(thr_arr[i]),
      .hit(hit[i]));
    assign cnt_flat[i*CW +: CW] = cnt_arr[i];
  end

  evb_irq #(.NCNT(NCNT)) u_irq (
    .clk(clk), .rst_n(rst_n), .hit(hit),
    .ien_we(wr_en && addr == RA_IEN), .iact_we(wr_en && addr == RA_IACT),
    .wbits(wdata[NCNT-1:0]), .ien_q(ien_q), .act_q(act_q), .irq(irq));

  evb_names #(.NCOND(NCOND)) u_names (.cidx(cidx_q), .name_lo(name_lo), .name_hi(name_hi));

  always_comb begin
    sel_cnt = '0;
    sel_thr = '0;
    sel_cfg = '0;
    for (int i = 0; i < NCNT; i++)
      if (sel_q == 5'(i)) begin
        sel_cnt = cnt_arr[i];
        sel_thr = thr_arr[i];
        sel_cfg = cfg_arr[i];
      end
  end

  always_comb begin
    sel_d   = (wr_en && addr == RA_SEL)  ? wdata[4:0]  : sel_q;
    cidx_d  = (wr_en && addr == RA_CIDX) ? wdata[15:0] : cidx_q;
    run_d   = (wr_en && addr == RA_CTRL) ? wdata[CTRL_RUN_BIT] : run_q;
    snap_en = wr_en && addr == RA_CTRL && wdata[CTRL_SNAP_BIT];
    snap_d  = sel_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      cidx_q <= '0;
      run_q  <= 1'b0;
      snap_q <= '0;
    end else begin
      sel_q  <= sel_d;
      cidx_q <= cidx_d;
      run_q  <= run_d;
      if (snap_en) snap_q <= snap_d;
    end
  end

  always_comb begin
    unique case (addr)
      RA_CTRL:  rdata = {31'd0, run_q};
      RA_SEL:   rdata = {27'd0, sel_q};
      RA_CFG:   rdata = {14'd0, sel_cfg.kern_only, sel_cfg.user_only, 1'b0, sel_cfg.cond};
      RA_CNTL:  rdata = sel_cnt[31:0];
      RA_CNTH:  rdata = 32'(sel_cnt[CW-1:32]);
      RA_THRL:  rdata = sel_thr[31:0];
      RA_THRH:  rdata = 32'(sel_thr[CW-1:32]);
      RA_SNPL:  rdata = snap_q[31:0];
      RA_SNPH:  rdata = 32'(snap_q[CW-1:32]);
      RA_IEN:   rdata = 32'(ien_q);
      RA_IACT:  rdata = 32'(act_q);
      RA_BUILD: rdata = {8'(NCOND), 6'd0, 2'(SZ), 1'b0, 1'b1, 6'(NCNT), 7'd0, 1'b1};
      RA_CIDX:  rdata = {16'd0, cidx_q};
      RA_NAME0: rdata = name_lo;
      RA_NAME1: rdata = name_hi;
      default:  rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/evb_checker.sv
module evb_checker #(
  parameter int NCNT = 4,
  parameter int CW   = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [3:0]       addr,
  input logic [31:0]      wdata,
  input logic             run_q,
  input logic [NCNT-1:0]  ien_q,
  input logic [NCNT-1:0]  act_q,
  input logic [NCNT*CW-1:0] cnt_flat,
  input logic [CW-1:0]    sel_cnt,
  input logic [CW-1:0]    snap_q
);
  // R2: snapshot captures the selected count on the command edge
  a_r2_snap_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd0 && wdata[1]) |=> (snap_q == $past(sel_cnt)));

  // R3: with run clear and no register write, no count moves
  a_r3_frozen_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_en) |=> $stable(cnt_flat));

  // R7: a newly set active bit needs its enable set in the prior cycle
  a_r7_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((act_q & ~$past(act_q) & ~$past(ien_q)) == '0));

  // R8: clearing write removes both active and enable bits
  a_r8_clear_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd10) |=>
      (((ien_q | act_q) & $past(wdata[NCNT-1:0])) == '0));
endmodule

bind evcnt_bank evb_checker #(.NCNT(NCNT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .run_q(run_q), .ien_q(ien_q), .act_q(act_q), .cnt_flat(cnt_flat),
  .sel_cnt(sel_cnt), .snap_q(snap_q));

// File: tb/tb_evcnt_bank.sv
module tb_evcnt_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCNT  = 4;
  localparam int NCOND = 8;
  localparam int SZ    = 1;
  localparam int CW    = 32 + 16 * SZ;
  localparam logic [63:0] CMASK = (64'd1 << CW) - 64'd1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [3:0]       addr = '0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic [NCOND-1:0] evt_in = '0;
  logic             user_mode = 1'b0;
  logic             irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] last_cnt [NCNT];

  evcnt_bank #(.NCNT(NCNT), .NCOND(NCOND), .SZ(SZ)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt_in(evt_in), .user_mode(user_mode), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    summary();
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    #1 d = rdata;
  endtask

  task automatic rd_cnt(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(4'd3, lo);
    rd(4'd4, hi);
    v = {hi, lo};
  endtask

  // drives n cycles of random events and mode; models the count
  task automatic drive(input int n, input int cond, input bit uo, input bit ko,
                       input bit run, inout logic [63:0] cnt);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      evt_in = NCOND'($urandom);
      user_mode = 1'($urandom);
      if (run && cond != 0 && cond < NCOND && evt_in[cond] &&
          !(uo && !user_mode) && !(ko && user_mode))
        cnt = (cnt + 64'd1) & CMASK;
    end
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic pulses(input int n, input int cond, input bit mode);
    for (int c = 0; c < n; c++) begin
      @(negedge clk); evt_in = NCOND'(1) << cond; user_mode = mode;
      @(negedge clk); evt_in = '0;
    end
  endtask

  function automatic logic [63:0] exp_name(input int idx);
    string s;
    logic [63:0] v;
    if (idx >= NCOND) return 64'd0;
    s = (idx == 0) ? "NEVER   " : $sformatf("EVT_%04X", idx);
    for (int b = 0; b < 8; b++) v[8*b +: 8] = s[b];
    return v;
  endfunction

  initial begin
    logic [31:0] r, r2;
    logic [63:0] v, e;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(4'd0, r);  chk("R11 run after reset", r, 0);
    rd(4'd10, r); chk("R11 active after reset", r, 0);
    rd(4'd9, r);  chk("R11 enable after reset", r, 0);
    chk("R11 irq after reset", irq, 0);
    for (int i = 0; i < NCNT; i++) begin
      wr(4'd1, i);
      rd_cnt(v); chk("R11 count after reset", v, 0);
      rd(4'd2, r); chk("R11 cfg after reset", r, 0);
      rd(4'd5, r); chk("R11 threshold after reset", r, 0);
      last_cnt[i] = 0;
    end

    // R9 build word
    rd(4'd11, r);
    chk("R9 build", r, 32'd1 | (NCNT << 8) | (1 << 14) | (SZ << 16) | (NCOND << 24));

    // R10 names, including one past the last code
    for (int k = 0; k <= NCOND; k++) begin
      wr(4'd12, k);
      rd(4'd13, r); rd(4'd14, r2);
      chk($sformatf("R10 name of %0d", k), {r2, r}, exp_name(k));
    end

    // R3 upper control bits
    wr(4'd0, 32'hFFFF_0001);
    rd(4'd0, r); chk("R3 control upper bits", r, 1);

    // R6/R2 load across the 32-bit boundary, then snapshot
    wr(4'd1, 0); wr(4'd2, 1);
    wr(4'd3, 32'hFFFF_FFFF); wr(4'd4, 0);
    pulses(1, 1, 0);
    wr(4'd0, 32'h3);
    rd(4'd8, r); rd(4'd7, r2);
    chk("R2 snapshot across carry", {r, r2}, 64'h1_0000_0000);
    pulses(3, 1, 0);
    rd(4'd7, r2); chk("R2 snapshot holds", r2, 0);
    rd_cnt(v); chk("R6 live count", v, 64'h1_0000_0003);

    // R3 freeze
    wr(4'd0, 0);
    e = v;
    drive(20, 1, 0, 0, 0, e);
    rd_cnt(v); chk("R3 frozen count", v, 64'h1_0000_0003);

    // R4 condition zero never counts
    wr(4'd0, 1); wr(4'd2, 0);
    repeat (10) begin @(negedge clk); evt_in = '1; end
    @(negedge clk); evt_in = '0;
    rd_cnt(v); chk("R4 code zero never", v, 64'h1_0000_0003);
    last_cnt[0] = v;
    wr(4'd2, 0);

    // R5 privilege qualifiers on counter 1
    wr(4'd1, 1); wr(4'd3, 0); wr(4'd4, 0);
    wr(4'd2, 32'd2 | (1 << 16));
    pulses(5, 2, 0);
    rd_cnt(v); chk("R5 user-only in kernel", v, 0);
    pulses(5, 2, 1);
    rd_cnt(v); chk("R5 user-only in user", v, 5);
    wr(4'd2, 32'd2 | (1 << 17));
    pulses(4, 2, 1);
    rd_cnt(v); chk("R5 kernel-only in user", v, 5);
    pulses(4, 2, 0);
    rd_cnt(v); chk("R5 kernel-only in kernel", v, 9);
    wr(4'd2, 0);
    last_cnt[1] = 9;

    // R1 out-of-range select
    wr(4'd1, NCNT); wr(4'd3, 32'h1234_5678);
    rd(4'd3, r); chk("R1 out-of-range read", r, 0);

    // R1/R4/R5/R6 random rounds
    for (int rnd = 0; rnd < 24; rnd++) begin
      int c, cond;
      bit uo, ko;
      c = $urandom % NCNT;
      cond = (rnd % 6 == 5) ? NCOND + 3 : 1 + ($urandom % (NCOND - 1));
      uo = 1'($urandom); ko = (rnd % 4 == 0) ? 1'($urandom) : 1'b0;
      e = {16'd0, 16'($urandom), 32'($urandom)};
      wr(4'd1, c);
      wr(4'd3, e[31:0]); wr(4'd4, e[63:32]);
      wr(4'd2, 32'(cond) | (32'(uo) << 16) | (32'(ko) << 17));
      drive(30, cond, uo, ko, 1, e);
      wr(4'd2, 0);
      rd_cnt(v); chk($sformatf("R4 R5 R6 round %0d", rnd), v, e);
      last_cnt[c] = e;
    end
    for (int i = 0; i < NCNT; i++) begin
      wr(4'd1, i);
      rd_cnt(v); chk($sformatf("R1 counter %0d isolated", i), v, last_cnt[i]);
    end

    // R7/R8 threshold interrupt on counter 2
    wr(4'd1, 2); wr(4'd2, 5);
    wr(4'd3, 0); wr(4'd4, 0);
    wr(4'd5, 3); wr(4'd6, 0);
    wr(4'd10, 32'hF); wr(4'd9, 32'h4); wr(4'd0, 1);
    for (int p = 0; p < 3; p++) begin
      @(negedge clk); evt_in = NCOND'(1) << 5;
      @(negedge clk); evt_in = '0;
    end
    #1 chk("R7 irq not before next edge", irq, 0);
    @(negedge clk);
    #1 chk("R7 irq after match", irq, 1);
    wr(4'd0, 0);
    rd(4'd10, r); chk("R7 only enabled counter active", r, 32'h4);
    wr(4'd10, 32'h4);
    rd(4'd10, r); chk("R8 active cleared", r, 0);
    rd(4'd9, r);  chk("R8 enable cleared", r, 0);
    rd(4'd10, r); chk("R8 active stays clear", r, 0);
    chk("R8 irq low", irq, 0);

    summary();
  end
endmodule